// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block is the address-sequencing part of a microprogrammed control unit whose control store holds 128 words of 20 bits. It owns the 7-bit control address register, which selects the microinstruction being executed, and a one-deep subroutine return register. Each cycle it takes the microinstruction word read from the store, the 4-bit opcode of the current machine instruction and three datapath status bits. From these it works out the control address for the following cycle.

A 2-bit condition field picks one test bit. A 2-bit branch field then chooses the source of the next address: the address field of the word, the incremented current address, the saved return address, or a routine address formed from the opcode. Each opcode maps to a four-word routine in the lower half of the store. The fetch routine starts at word 64. The block only computes addresses. The store contents and the decoding of the micro-operation fields belong elsewhere.

Top module: `useq_next_addr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the control address becomes 64 and the return register becomes 0. A return issued straight after reset therefore goes to address 0.
- R2: When `run_en` is low at a clock edge, the control address and the return register keep their values.
- R3: Condition field `uinstr[10:9]` selects the test bit: 00 is always true, 01 is `ind_bit`, 10 is `ac_sign`, 11 is `ac_zero`.
- R4: With branch field `uinstr[8:7]` = 00 (jump) and a true condition, the next address is the address field `uinstr[6:0]`.
- R5: With branch field 00 or 01 and a false condition, the next address is the current address plus one, modulo 128, so 127 is followed by 0.
- R6: With branch field 01 (call) and a true condition, the next address is the address field, and the current address plus one (modulo 128) is written to the return register.
- R7: A call whose condition is false leaves the return register unchanged.
- R8: With branch field 10 (return), the next address is the return register content, whatever the condition and address fields hold.
- R9: With branch field 11 (map), the next address is binary 0, opcode[3:0], 00, that is opcode times 4, whatever the condition and address fields hold.
- R10: `next_addr` shows combinationally the address that the control register loads at the next enabled edge.
- R11: Bits `uinstr[19:11]` (the micro-operation fields) have no effect on `next_addr`, `car` or the return register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Enables the address and return register updates |
| uinstr | input | 20 | Current microinstruction word |
| opcode | input | 4 | Opcode of the current machine instruction |
| ind_bit | input | 1 | Indirect-addressing bit of the machine instruction |
| ac_sign | input | 1 | Accumulator sign status |
| ac_zero | input | 1 | Accumulator zero status |
| car | output | 7 | Current control address (register) |
| next_addr | output | 7 | Next control address (combinational) |

## Verification
A wrong control address shows on `car` in the cycle right after the faulty edge, and it stays wrong because every later increment builds on it. A corrupted or wrongly written return register stays hidden until the next return. It then appears as a bad `car` one edge after that return. For this reason the sweep issues a return every fourth step, which makes any error in the register visible within four cycles. Condition selection faults show as a jump taken where an increment was due, or the reverse, on the same edge.

// File: rtl/useq_pkg.sv
// Package: shared encodings for the microprogram sequencer.
// Assumes the condition and branch fields are both two bits wide.
package useq_pkg;

    // Test bit chosen by the condition field
    typedef enum logic [1:0] {
        COND_ALWAYS = 2'b00,
        COND_IND    = 2'b01,
        COND_SIGN   = 2'b10,
        COND_ZERO   = 2'b11
    } cond_e;

    // Source of the next control address chosen by the branch field
    typedef enum logic [1:0] {
        BR_JUMP = 2'b00,
        BR_CALL = 2'b01,
        BR_RET  = 2'b10,
        BR_MAP  = 2'b11
    } br_e;

    localparam int COND_W = 2;
    localparam int BR_W   = 2;

endpackage

// File: rtl/useq_cond_sel.sv
// Module: useq_cond_sel
// Chooses one status bit, or constant true, from the condition field.
// Assumes the status inputs are stable for the whole cycle.
module useq_cond_sel
    import useq_pkg::*;
(
    input  cond_e sel,
    input  logic  ind_bit,
    input  logic  ac_sign,
    input  logic  ac_zero,
    output logic  taken
);

    // Purpose: four-way selection of the test bit
    always_comb begin
        case (sel)
            COND_ALWAYS: taken = 1'b1;
            COND_IND:    taken = ind_bit;
            COND_SIGN:   taken = ac_sign;
            COND_ZERO:   taken = ac_zero;
            default:     taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/useq_next_mux.sv
// Module: useq_next_mux
// Forms the next control address from branch type and condition.
// Also raises the return-register write strobe for a taken call.
// Assumes AW >= OW + 2 so that an opcode routine address fits.
module useq_next_mux
    import useq_pkg::*;
#(
    parameter int AW = 7,
    parameter int OW = 4
) (
    input  br_e           br,
    input  logic          taken,
    input  logic [AW-1:0] car,
    input  logic [AW-1:0] ad,
    input  logic [AW-1:0] sbr,
    input  logic [OW-1:0] opc,
    output logic [AW-1:0] nxt,
    output logic [AW-1:0] incr,
    output logic          save
);

    localparam int PAD_W = AW - OW - 2;

    logic [AW-1:0] map_addr;

    // Purpose: combinational incrementer, wraps at the top of the store
    always_comb incr = car + AW'(1);

    // Purpose: routine address = zero pad, opcode, two zero bits
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb map_addr = {{PAD_W{1'b0}}, opc, 2'b00};
        end else begin : g_nopad
            always_comb map_addr = {opc, 2'b00};
        end
    endgenerate

    // Purpose: four-way address multiplexer steered by branch and condition
    always_comb begin
        save = 1'b0;
        case (br)
            BR_JUMP: nxt = taken ? ad : incr;
            BR_CALL: begin
                nxt  = taken ? ad : incr;
                save = taken;
            end
            BR_RET:  nxt = sbr;
            BR_MAP:  nxt = map_addr;
            default: nxt = incr;
        endcase
    end

endmodule

// File: rtl/useq_ret_reg.sv
// Module: useq_ret_reg
// One-deep subroutine return address holder.
// Assumes the write strobe is already qualified by the run enable.
module useq_ret_reg #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] d,
    output logic [AW-1:0] q
);

    // Purpose: capture the return address on a qualified write
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= d;
    end

endmodule

// File: rtl/useq_next_addr.sv
// Module: useq_next_addr (top)
// Control address register plus next-address logic for a microprogrammed
// control store. Word layout from the MSB down: micro-op fields (ignored
// here), condition field, branch field, address field.
// Assumes the microinstruction word belongs to the current car value.
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int AW         = 7,
    parameter int OW         = 4,
    parameter int MOP_W      = 3,
    parameter int MOP_N      = 3,
    parameter int RESET_ADDR = 64,
    localparam int UW        = MOP_N * MOP_W + COND_W + BR_W + AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [UW-1:0] uinstr,
    input  logic [OW-1:0] opcode,
    input  logic          ind_bit,
    input  logic          ac_sign,
    input  logic          ac_zero,
    output logic [AW-1:0] car,
    output logic [AW-1:0] next_addr
);

    localparam int BR_LSB   = AW;
    localparam int COND_LSB = AW + BR_W;

    cond_e         f_cond;
    br_e           f_br;
    logic [AW-1:0] f_ad;
    logic          taken;
    logic          save;
    logic [AW-1:0] incr;
    logic [AW-1:0] sbr_q;

    // Purpose: slice the sequencing fields out of the word
    always_comb begin
        f_cond = cond_e'(uinstr[COND_LSB +: COND_W]);
        f_br   = br_e'(uinstr[BR_LSB +: BR_W]);
        f_ad   = uinstr[AW-1:0];
    end

    useq_cond_sel u_cond (
        .sel     (f_cond),
        .ind_bit (ind_bit),
        .ac_sign (ac_sign),
        .ac_zero (ac_zero),
        .taken   (taken)
    );

    useq_next_mux #(.AW(AW), .OW(OW)) u_mux (
        .br    (f_br),
        .taken (taken),
        .car   (car),
        .ad    (f_ad),
        .sbr   (sbr_q),
        .opc   (opcode),
        .nxt   (next_addr),
        .incr  (incr),
        .save  (save)
    );

    useq_ret_reg #(.AW(AW)) u_ret (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (save && run_en),
        .d     (incr),
        .q     (sbr_q)
    );

    // Purpose: control address register, loads the fetch start on reset
    always_ff @(posedge clk) begin
        if (!rst_n)      car <= AW'(RESET_ADDR);
        else if (run_en) car <= next_addr;
    end

    // Hold when disabled
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ($stable(car) && $stable(sbr_q)));

    // Jump/call with a true condition reaches the address field
    assert_jump_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && (f_br == BR_JUMP || f_br == BR_CALL) && taken) |=> car == $past(f_ad));

    // Not taken: step by one
    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && (f_br == BR_JUMP || f_br == BR_CALL) && !taken) |=> car == $past(car) + AW'(1));

    // Taken call saves the return address
    assert_call_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && f_br == BR_CALL && taken) |=> sbr_q == $past(car) + AW'(1));

    // Return register untouched except by a taken call
    assert_ret_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_en && f_br == BR_CALL && taken) |=> $stable(sbr_q));

    // Return goes to the saved address
    assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && f_br == BR_RET) |=> car == $past(sbr_q));

    // Opcode mapping gives a four-word aligned routine in the lower half
    assert_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && f_br == BR_MAP) |=>
        (car[1:0] == 2'b00 && car[AW-1] == 1'b0 && car[OW+1:2] == $past(opcode)));

endmodule

// File: tb/useq_next_addr_tb.sv
module useq_next_addr_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run_en;
    logic [19:0] uinstr;
    logic [3:0]  opcode;
    logic        ind_bit, ac_sign, ac_zero;
    logic [6:0]  car, next_addr;

    int n_run  = 0;
    int n_fail = 0;
    logic [6:0] m_car, m_sbr;

    always #2 clk = ~clk;   // 250 MHz

    useq_next_addr u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .uinstr(uinstr),
        .opcode(opcode), .ind_bit(ind_bit), .ac_sign(ac_sign),
        .ac_zero(ac_zero), .car(car), .next_addr(next_addr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Model of the next address from the requirements (R3..R9)
    function automatic logic [7:0] model_next(input logic [1:0] br, input logic [1:0] cd,
            input logic [6:0] ad, input logic [3:0] opc, input logic i, input logic s,
            input logic z);
        logic c;
        logic [6:0] n;
        logic sv;
        c  = (cd == 2'd0) ? 1'b1 : (cd == 2'd1) ? i : (cd == 2'd2) ? s : z;
        sv = 1'b0;
        case (br)
            2'd0: n = c ? ad : m_car + 7'd1;
            2'd1: begin n = c ? ad : m_car + 7'd1; sv = c; end
            2'd2: n = m_sbr;
            default: n = {1'b0, opc, 2'b00};
        endcase
        return {sv, n};
    endfunction

    task automatic step(input logic en, input logic [1:0] br, input logic [1:0] cd,
            input logic [6:0] ad, input logic [8:0] up, input logic [3:0] opc,
            input logic i, input logic s, input logic z, input string tag);
        logic [7:0] r;
        @(negedge clk);
        run_en = en; uinstr = {up, cd, br, ad}; opcode = opc;
        ind_bit = i; ac_sign = s; ac_zero = z;
        #1;
        r = model_next(br, cd, ad, opc, i, s, z);
        chk("R10 next_addr", int'(next_addr), int'(r[6:0]));
        @(posedge clk); #1;
        if (en) begin
            if (br == 2'd1 && r[7]) m_sbr = m_car + 7'd1;
            m_car = r[6:0];
        end
        chk(tag, int'(car), int'(m_car));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; run_en = 1'b0;
        @(posedge clk); #1;
        m_car = 7'd64; m_sbr = 7'd0;
        chk("R1 reset car", int'(car), 64);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [6:0] na0;
        rst_n = 1'b0; run_en = 1'b0; uinstr = '0; opcode = '0;
        ind_bit = 0; ac_sign = 0; ac_zero = 0;
        m_car = 7'd64; m_sbr = 7'd0;
        do_reset();
        // R1: return register cleared
        step(1'b1, 2'd2, 2'd0, 7'd55, 9'd0, 4'd3, 0, 0, 0, "R1 ret after reset");

        // Near-exhaustive sweep over branch, condition, status, opcode, enable
        for (int k = 0; k < 4096; k++) begin
            logic [1:0] br, cd;
            logic en;
            string tag;
            br = k[1:0];
            cd = k[3:2];
            en = (k % 7) != 3;
            if (!en)            tag = "R2 hold";
            else if (br == 2'd3) tag = "R9 map";
            else if (br == 2'd2) tag = "R8 R7 return";
            else if (br == 2'd1) tag = "R6 R5 R3 call";
            else if (cd == 2'd0) tag = "R4 jump";
            else                 tag = "R3 R5 cond jump";
            step(en, br, cd, 7'((k * 37 + 11) % 128), 9'((k * 91 + 5) % 512),
                 4'((k >> 4) % 16), k[4], k[5], k[6], tag);
        end

        // R5: increment wraps 127 -> 0
        step(1'b1, 2'd0, 2'd0, 7'd127, 9'd0, 4'd0, 0, 0, 0, "R4 jump to 127");
        step(1'b1, 2'd0, 2'd3, 7'd9, 9'd0, 4'd0, 0, 0, 0, "R5 wrap");
        chk("R5 wrap value", int'(car), 0);
        // R6: call from 127 saves 0
        step(1'b1, 2'd0, 2'd0, 7'd127, 9'd0, 4'd0, 0, 0, 0, "R4 jump to 127");
        step(1'b1, 2'd1, 2'd0, 7'd20, 9'd0, 4'd0, 0, 0, 0, "R6 call");
        step(1'b1, 2'd2, 2'd1, 7'd99, 9'd0, 4'd0, 0, 0, 0, "R8 return");
        chk("R6 saved wrap", int'(car), 0);

        // R11: micro-op bits do not change next address
        @(negedge clk);
        run_en = 1'b0; uinstr = {9'h000, 2'b10, 2'b00, 7'd33}; ac_sign = 1'b0;
        #1 na0 = next_addr;
        uinstr[19:11] = 9'h1FF;
        #1 chk("R11 upper bits", int'(next_addr), int'(na0));

        // R1: reset in mid-run
        do_reset();
        step(1'b1, 2'd3, 2'd2, 7'd1, 9'd0, 4'd15, 0, 1, 0, "R9 map 15");
        chk("R9 map 15 value", int'(car), 60);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule